// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This block sends a fixed number of clock-enable pulses toward a configuration port when software asks for them. Software writes a pulse count into a count register through a simple single-cycle register port. The block then raises a one-cycle enable on every other clock cycle until that many pulses have gone out. A sticky completion flag in a status register then goes high. Software clears the flag by writing a one to its bit.

The usual sequence has three steps. Software clears any stale completion flag, writes the count (for example 4 to finish a start-up sequence), and polls the status register until it reads exactly 0x1. While a burst runs, the count register reads back how many pulses are still owed.

There is no data stream in this block. The register port and the pulse output are plain control signals with no valid/ready handshake. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`.

Top module: `burst_clk_gen`

## Requirements
- R1: After reset, the count register reads 0, the status register reads 0 and `pulse_en` is low.
- R2: The count register sits at byte offset 0x8 and the status register at 0xC. Status bit 0 is the done flag and every other status bit reads 0, so the status reads 0x1 when done and 0x0 otherwise. Offsets 0x0 and 0x4 read 0.
- R3: A write of N > 0 to the count register while idle produces exactly N pulses. The done flag becomes visible 2N-1 clock edges after the write edge, which is the cycle after the last pulse.
- R4: Each pulse is high for one cycle only, and pulses fall on alternate cycles. The first pulse is in the cycle right after the write edge.
- R5: The count register reads the number of pulses still to be sent. It drops by one at the edge that ends each pulse and reads 0 after the burst.
- R6: A count write that arrives while a burst runs is ignored. The remaining count and the number of pulses are unchanged by it.
- R7: A status write with data bit 0 = 1 clears the done flag. A status write with bit 0 = 0 leaves it unchanged.
- R8: A count of 0 produces no pulse and sets the done flag at the write edge itself, so it is visible in the next cycle.
- R9: The done flag is sticky. Starting a new burst does not clear it. When a burst completes at the same edge as a clearing write, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| pulse_en | output | 1 | Single-cycle clock-enable pulse toward the configuration port |

## Verification
The hardest situation to reach is a burst finishing on the same edge as a clearing write to the status register. The stimulus gets there with a one-pulse burst and a status write driven in the cycle of that single pulse. The bench then checks that the flag survives the clear. Ignoring a count write during a burst is also hard to observe from outside. The bench writes a different count in mid-burst, reads the remaining count right after, and checks the total burst length against the original request.

// File: rtl/burst_clk_pkg.sv
package burst_clk_pkg;
  localparam int unsigned OFS_COUNT  = 32'h8;
  localparam int unsigned OFS_STATUS = 32'hC;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_STATUS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/burst_regdec.sv
module burst_regdec
  import burst_clk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  remaining,
  input  logic              done,
  output logic              cnt_wr,
  output logic              clr_wr,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  reg_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr == A_COUNT)       sel = SEL_COUNT;
    else if (reg_addr == A_STATUS) sel = SEL_STATUS;
  end

  assign cnt_wr = reg_wr && (sel == SEL_COUNT);
  assign clr_wr = reg_wr && (sel == SEL_STATUS) && reg_wdata[0];

  generate
    if (CNT_W < DATA_W) begin : g_pad
      always_comb begin
        reg_rdata = '0;
        case (sel)
          SEL_COUNT:  reg_rdata = {{(DATA_W-CNT_W){1'b0}}, remaining};
          SEL_STATUS: reg_rdata = {{(DATA_W-1){1'b0}}, done};
          default:    reg_rdata = '0;
        endcase
      end
    end else begin : g_full
      always_comb begin
        reg_rdata = '0;
        case (sel)
          SEL_COUNT:  reg_rdata = remaining[DATA_W-1:0];
          SEL_STATUS: reg_rdata = {{(DATA_W-1){1'b0}}, done};
          default:    reg_rdata = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/burst_engine.sv
module burst_engine #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remaining,
  output logic             busy,
  output logic             pulse_en,
  output logic             finish
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      busy      <= 1'b0;
      phase     <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        remaining <= load_val;
        busy      <= (load_val != '0);
        phase     <= 1'b0;
      end
    end else if (!phase) begin
      remaining <= remaining - ONE;
      phase     <= 1'b1;
      if (remaining == ONE) busy <= 1'b0;
    end else begin
      phase <= 1'b0;
    end
  end

  assign pulse_en = busy && !phase;
  assign finish   = (!busy && load && (load_val == '0)) ||
                    (busy && !phase && (remaining == ONE));
endmodule

// File: rtl/burst_done_flag.sv
module burst_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done <= 1'b0;
    else if (set_evt) done <= 1'b1;
    else if (clr_evt) done <= 1'b0;
  end
endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pulse_en
);
  logic             cnt_wr;
  logic             clr_wr;
  logic [CNT_W-1:0] remaining;
  logic             busy;
  logic             finish;
  logic             done;

  burst_regdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .remaining (remaining),
    .done      (done),
    .cnt_wr    (cnt_wr),
    .clr_wr    (clr_wr),
    .reg_rdata (reg_rdata)
  );

  burst_engine #(.CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_wr),
    .load_val  (reg_wdata[CNT_W-1:0]),
    .remaining (remaining),
    .busy      (busy),
    .pulse_en  (pulse_en),
    .finish    (finish)
  );

  burst_done_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (finish),
    .clr_evt (clr_wr),
    .done    (done)
  );
endmodule

// File: rtl/burst_clk_gen_chk.sv
module burst_clk_gen_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              pulse_en,
  input logic              cnt_wr,
  input logic              clr_wr,
  input logic [CNT_W-1:0]  remaining,
  input logic              busy,
  input logic              finish,
  input logic              done
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(burst_clk_pkg::OFS_STATUS);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  assert_pulse_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |=> !pulse_en);

  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |=> (remaining == $past(remaining) - ONE));

  assert_last_pulse_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_en && remaining == ONE) |=> done);

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_wr && !pulse_en) |=> $stable(remaining));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !finish) |=> !done);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_wr) |=> done);

  assert_status_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STATUS) |-> (reg_rdata == {{(DATA_W-1){1'b0}}, done}));
endmodule

bind burst_clk_gen burst_clk_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .pulse_en  (pulse_en),
  .cnt_wr    (cnt_wr),
  .clr_wr    (clr_wr),
  .remaining (remaining),
  .busy      (busy),
  .finish    (finish),
  .done      (done)
);

// File: tb/tb_burst_clk_gen.sv
`timescale 1ns/1ps
module tb_burst_clk_gen;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NVEC   = 7;
  localparam logic [ADDR_W-1:0] A_CNT = 12'h8;
  localparam logic [ADDR_W-1:0] A_ST  = 12'hC;
  localparam int unsigned VEC_N   [NVEC] = '{1, 2, 3, 4, 5, 0, 7};
  localparam int unsigned VEC_LAT [NVEC] = '{1, 3, 5, 7, 9, 0, 13};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              pulse_en;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_clk_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_en(pulse_en)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    reg_addr = a;
    #0.2 d = reg_rdata;
  endtask

  // Called right after a count write edge; returns pulses seen and edges until done.
  task automatic watch(output int pulses, output int lat);
    logic [DATA_W-1:0] st;
    pulses = 0; lat = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      rd(A_ST, st);
      if (st[0]) break;
      if (pulse_en) pulses++;
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v;
    int p, l;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_CNT, v); check("R1 count after reset", v, 0);
    rd(A_ST, v);  check("R1 status after reset", v, 0);
    check("R1 pulse after reset", pulse_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R3, R4, R8 (N=0), count of 4
    for (int i = 0; i < NVEC; i++) begin
      wr(A_ST, 32'h1);
      rd(A_ST, v); check("R7 cleared before burst", v, 0);
      wr(A_CNT, VEC_N[i]);
      watch(p, l);
      check(VEC_N[i] == 0 ? "R8 zero count pulses" : "R3 pulse count", p, VEC_N[i]);
      check(VEC_N[i] == 0 ? "R8 zero count latency" : "R3 done latency", l, VEC_LAT[i]);
      rd(A_ST, v);  check("R2 status reads 0x1 when done", v, 1);
      rd(A_CNT, v); check("R5 remaining zero after burst", v, 0);
    end

    // R4 alternate-cycle pattern for N=3
    wr(A_ST, 32'h1);
    wr(A_CNT, 3);
    for (int c = 1; c <= 7; c++) begin
      @(negedge clk);
      check($sformatf("R4 pulse in cycle %0d", c), pulse_en, (c % 2 == 1 && c <= 5) ? 1 : 0);
    end

    // R5 + R6: read remaining, write new count mid-burst
    wr(A_ST, 32'h1);
    wr(A_CNT, 5);
    @(negedge clk);
    rd(A_CNT, v); check("R5 remaining in first pulse cycle", v, 5);
    wr(A_CNT, 2);              // edge E2, phase-off cycle
    @(negedge clk);
    rd(A_CNT, v); check("R6 remaining unchanged by busy write", v, 4);
    watch(p, l);
    check("R6 burst length kept (edges to done)", l + 3, 9);

    // R7 bit0=0 write no effect, bit0=1 clears
    wr(A_ST, 32'hFFFF_FFFE);
    rd(A_ST, v); check("R7 write with bit0 low keeps done", v, 1);
    wr(A_ST, 32'h1);
    rd(A_ST, v); check("R7 write one clears done", v, 0);

    // R2 other offsets read zero
    rd(12'h0, v); check("R2 offset 0x0 reads 0", v, 0);
    rd(12'h4, v); check("R2 offset 0x4 reads 0", v, 0);

    // R9 sticky across a new burst
    wr(A_CNT, 0);
    @(negedge clk);
    wr(A_CNT, 3);
    @(negedge clk);
    rd(A_ST, v); check("R9 done stays set while new burst runs", v, 1);
    check("R9 new burst still pulses", pulse_en, 1);
    repeat (6) @(negedge clk);
    rd(A_CNT, v); check("R9 burst completed", v, 0);

    // R9 completion coincides with clear
    wr(A_ST, 32'h1);
    wr(A_CNT, 1);              // E0; pulse in c1, completes at E1
    wr(A_ST, 32'h1);           // driven in c1, lands on E1
    @(negedge clk);
    rd(A_ST, v); check("R9 completion wins over clear", v, 1);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule